// File: doc/BRIEF.md
# Load-Store Data Aligner

This block is a purely combinational unit that sits between a 32-bit register file and a 32-bit, word-addressed data memory. For each memory-access opcode it forms the byte address by adding a sign-extended 16-bit displacement to a base register value. It then checks that halfword and word accesses are naturally aligned. It produces the data for the memory side of the access and for the register side.

For a store, the unit drives a four-bit byte-lane enable mask and a write word in which the narrow source value is repeated across every lane. The memory then writes only the lanes that the mask selects. For a load, the unit takes the word the memory returns, picks out the addressed byte, halfword or word, and widens it with sign or zero fill. It also raises a register write enable. Lanes are big-endian: byte offset 0 of a word is bits 31..24.

A misaligned access raises an address-error flag and suppresses every side effect. No lane is enabled and no register is written. Memory timing and any load-use delay are handled elsewhere.

Top module: `ldst_align`

## Requirements
- R1: `addr_o` equals `base_i` plus `offs_i` sign-extended to 32 bits, modulo 2^32, for every opcode.
- R2: Only these opcodes are accesses: 100000 load byte signed, 100100 load byte unsigned, 100001 load halfword signed, 100101 load halfword unsigned, 100011 load word, 101000 store byte, 101001 store halfword, 101011 store word. Any other opcode gives `be_o`=0, `wdata_o`=0, `ld_val_o`=0, `reg_we_o`=0 and `addr_err_o`=0. A store never asserts `reg_we_o`.
- R3: A byte load at byte offset k (addr_o[1:0]) takes `rd_word_i` bits [31-8k : 24-8k]. The signed form fills bits 31..8 with bit 7 of that byte, and the unsigned form fills them with zeros.
- R4: A halfword load at offset 0 takes `rd_word_i[31:16]`, and at offset 2 takes `rd_word_i[15:0]`. The signed form fills bits 31..16 with bit 15 of the halfword, and the unsigned form fills them with zeros.
- R5: An aligned word load returns `rd_word_i` unchanged with `reg_we_o`=1.
- R6: `addr_err_o` is 1 for a halfword access with addr_o[0]=1 and for a word access with addr_o[1:0]≠0. It is never 1 for a byte access.
- R7: A store with no error enables only the addressed lanes, where `be_o[3]` is bits 31..24. A byte at offset k sets bit 3-k. A halfword sets 4'b1100 at offset 0 and 4'b0011 at offset 2. A word sets 4'b1111.
- R8: For every store opcode, whatever the alignment, `wdata_o` is the low byte of `st_val_i` repeated four times, the low halfword of `st_val_i` repeated twice, or all of `st_val_i`, for byte, halfword and word stores respectively.
- R9: When `addr_err_o` is 1, `be_o`=0, `reg_we_o`=0 and `ld_val_o`=0. A load without error asserts `reg_we_o`, and `ld_val_o`=0 whenever `reg_we_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Access opcode |
| base_i | input | 32 | Base register value |
| offs_i | input | 16 | Signed displacement |
| st_val_i | input | 32 | Store source register value |
| rd_word_i | input | 32 | Word returned by the data memory |
| addr_o | output | 32 | Effective byte address |
| be_o | output | 4 | Byte-lane write enables, bit 3 = bits 31..24 |
| wdata_o | output | 32 | Lane-replicated store data |
| ld_val_o | output | 32 | Extended load result for the register file |
| reg_we_o | output | 1 | Register write enable for loads |
| addr_err_o | output | 1 | Misaligned access flag |

## Verification
The bench builds the block with its default 32-bit data width and 16-bit displacement, which is the only shape the opcode semantics define. These widths bring every lane offset within reach: each byte offset of the byte loads and stores, both halfword positions, and all three misaligned word offsets. They also cover address wrap-around from a negative displacement. Data with the sign bit of the selected byte or halfword both set and clear separates the signed loads from the unsigned ones, and opcodes adjacent to the valid codes confirm that they stay inert.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int WORD_W = 32;
  localparam int DISP_W = 16;
  localparam int OP_W   = 6;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;

  localparam logic [OP_W-1:0] OP_LDB  = 6'b100000;
  localparam logic [OP_W-1:0] OP_LDH  = 6'b100001;
  localparam logic [OP_W-1:0] OP_LDW  = 6'b100011;
  localparam logic [OP_W-1:0] OP_LDBU = 6'b100100;
  localparam logic [OP_W-1:0] OP_LDHU = 6'b100101;
  localparam logic [OP_W-1:0] OP_STB  = 6'b101000;
  localparam logic [OP_W-1:0] OP_STH  = 6'b101001;
  localparam logic [OP_W-1:0] OP_STW  = 6'b101011;

  // Widen a displacement to the address width with its sign bit.
  function automatic logic [WORD_W-1:0] widen_disp(input logic [DISP_W-1:0] d);
    return {{(WORD_W-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  // Widen a narrow value held in the low bits, with or without sign fill.
  function automatic logic [WORD_W-1:0] widen_val(input logic [WORD_W-1:0] v,
                                                  input int unsigned bits,
                                                  input logic fill_sign);
    logic [WORD_W-1:0] mask;
    logic              s;
    mask = (WORD_W'(1) << bits) - WORD_W'(1);
    s    = fill_sign & v[bits-1];
    return (v & mask) | ({WORD_W{s}} & ~mask);
  endfunction
endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
  import lsa_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            is_load_o,
  output logic            is_store_o,
  output logic            unsigned_o,
  output acc_size_e       size_o
);
  always_comb begin
    is_load_o  = 1'b0;
    is_store_o = 1'b0;
    unsigned_o = 1'b0;
    size_o     = SZ_BYTE;
    case (op_i)
      OP_LDB:  begin is_load_o = 1'b1;  size_o = SZ_BYTE; end
      OP_LDBU: begin is_load_o = 1'b1;  size_o = SZ_BYTE; unsigned_o = 1'b1; end
      OP_LDH:  begin is_load_o = 1'b1;  size_o = SZ_HALF; end
      OP_LDHU: begin is_load_o = 1'b1;  size_o = SZ_HALF; unsigned_o = 1'b1; end
      OP_LDW:  begin is_load_o = 1'b1;  size_o = SZ_WORD; end
      OP_STB:  begin is_store_o = 1'b1; size_o = SZ_BYTE; end
      OP_STH:  begin is_store_o = 1'b1; size_o = SZ_HALF; end
      OP_STW:  begin is_store_o = 1'b1; size_o = SZ_WORD; end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsa_align_chk.sv
module lsa_align_chk
  import lsa_pkg::*;
#(
  parameter int AL_W = 2
) (
  input  logic            access_i,
  input  acc_size_e       size_i,
  input  logic [AL_W-1:0] addr_lo_i,
  output logic            err_o
);
  logic half_bad, word_bad;
  assign half_bad = (size_i == SZ_HALF) && addr_lo_i[0];
  assign word_bad = (size_i == SZ_WORD) && (addr_lo_i != '0);
  assign err_o    = access_i && (half_bad || word_bad);
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int AL_W  = $clog2(LANES)
) (
  input  logic              is_store_i,
  input  logic              err_i,
  input  acc_size_e         size_i,
  input  logic [AL_W-1:0]   addr_lo_i,
  input  logic [DATA_W-1:0] st_val_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);
  // Lane l is byte offset l; big-endian, so lane 0 is the top byte.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       hit;
    logic [7:0] lane_d;
    assign hit = (size_i == SZ_BYTE) ? (addr_lo_i == AL_W'(l)) :
                 (size_i == SZ_HALF) ? (addr_lo_i[AL_W-1:1] == (AL_W-1)'(l / 2)) :
                                       1'b1;
    assign lane_d = (size_i == SZ_BYTE) ? st_val_i[7:0] :
                    (size_i == SZ_HALF) ? ((l % 2 == 0) ? st_val_i[15:8] : st_val_i[7:0]) :
                                          st_val_i[DATA_W-1-8*l -: 8];
    assign be_o[LANES-1-l]                 = is_store_i && !err_i && hit;
    assign wdata_o[DATA_W-1-8*l -: 8]      = is_store_i ? lane_d : 8'h00;
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int AL_W  = $clog2(LANES)
) (
  input  logic              is_load_i,
  input  logic              err_i,
  input  logic              unsigned_i,
  input  acc_size_e         size_i,
  input  logic [AL_W-1:0]   addr_lo_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] ld_val_o,
  output logic              reg_we_o
);
  logic [7:0]  lane_b [LANES];
  logic [15:0] half_h [LANES/2];

  for (genvar l = 0; l < LANES; l++) begin : g_byte
    assign lane_b[l] = rd_word_i[DATA_W-1-8*l -: 8];
  end
  for (genvar h = 0; h < LANES/2; h++) begin : g_half
    assign half_h[h] = {lane_b[2*h], lane_b[2*h+1]};
  end

  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  assign byte_sel = lane_b[addr_lo_i];
  assign half_sel = half_h[addr_lo_i[AL_W-1:1]];
  assign reg_we_o = is_load_i && !err_i;

  always_comb begin
    ld_val_o = '0;
    if (reg_we_o) begin
      case (size_i)
        SZ_BYTE: ld_val_o = widen_val(DATA_W'(byte_sel), 8, !unsigned_i);
        SZ_HALF: ld_val_o = widen_val(DATA_W'(half_sel), 16, !unsigned_i);
        default: ld_val_o = rd_word_i;
      endcase
    end
  end
endmodule

// File: rtl/ldst_align.sv
module ldst_align
  import lsa_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int OFFS_W = DISP_W,
  localparam int LANES = DATA_W / 8,
  localparam int AL_W  = $clog2(LANES)
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic [DATA_W-1:0] st_val_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] ld_val_o,
  output logic              reg_we_o,
  output logic              addr_err_o
);
  logic      is_load, is_store, is_uns;
  acc_size_e acc_size;

  assign addr_o = base_i + widen_disp(offs_i);

  lsa_decode u_dec (
    .op_i(op_i), .is_load_o(is_load), .is_store_o(is_store),
    .unsigned_o(is_uns), .size_o(acc_size)
  );

  lsa_align_chk #(.AL_W(AL_W)) u_chk (
    .access_i(is_load || is_store), .size_i(acc_size),
    .addr_lo_i(addr_o[AL_W-1:0]), .err_o(addr_err_o)
  );

  lsa_store_lanes #(.DATA_W(DATA_W)) u_st (
    .is_store_i(is_store), .err_i(addr_err_o), .size_i(acc_size),
    .addr_lo_i(addr_o[AL_W-1:0]), .st_val_i(st_val_i),
    .be_o(be_o), .wdata_o(wdata_o)
  );

  lsa_load_extract #(.DATA_W(DATA_W)) u_ld (
    .is_load_i(is_load), .err_i(addr_err_o), .unsigned_i(is_uns),
    .size_i(acc_size), .addr_lo_i(addr_o[AL_W-1:0]), .rd_word_i(rd_word_i),
    .ld_val_o(ld_val_o), .reg_we_o(reg_we_o)
  );

  // Cross-module checks on the settled outputs of the sub-blocks.
  always_comb begin
    if (addr_err_o)
      a_r9_err_quiet: assert (be_o == '0 && !reg_we_o && ld_val_o == '0)
        else $error("error access left a side effect");
    if (be_o != '0)
      a_r2_store_no_we: assert (!reg_we_o)
        else $error("store raised register write");
    a_r7_be_shape: assert ($countones(be_o) inside {0, 1, 2, LANES})
      else $error("lane mask shape %b", be_o);
    if (acc_size == SZ_BYTE)
      a_r6_byte_never_err: assert (!addr_err_o)
        else $error("byte access flagged misaligned");
    if (reg_we_o && acc_size == SZ_BYTE && !is_uns)
      a_r3_byte_sext: assert (ld_val_o[DATA_W-1:7] == '0 || ld_val_o[DATA_W-1:7] == '1)
        else $error("signed byte load not sign filled");
  end
endmodule

// File: tb/test_ldst_align.sv
module test_ldst_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op;
  logic [31:0] base, sv, rw;
  logic [15:0] offs;
  logic [31:0] addr, wdata, ldv;
  logic [3:0]  be;
  logic        we, err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ldst_align i_ldst_align (
    .op_i(op), .base_i(base), .offs_i(offs), .st_val_i(sv), .rd_word_i(rw),
    .addr_o(addr), .be_o(be), .wdata_o(wdata), .ld_val_o(ldv),
    .reg_we_o(we), .addr_err_o(err)
  );

  typedef struct {
    logic [31:0] addr, wdata, ldv;
    logic [3:0]  be;
    logic        we, err;
    string       req;
  } exp_t;

  exp_t sb[$];

  function automatic exp_t model(logic [5:0] o, logic [31:0] b, logic [15:0] d,
                                 logic [31:0] s, logic [31:0] r, string req);
    exp_t e;
    logic [1:0] k;
    logic       ld, st, sgn;
    int         sz;
    logic [7:0]  by;
    logic [15:0] hw;
    e.req = req;
    e.addr = b + $unsigned(32'($signed(d)));
    k = e.addr[1:0];
    ld = 0; st = 0; sgn = 0; sz = 0;
    case (o)
      6'b100000: begin ld = 1; sz = 1; sgn = 1; end
      6'b100100: begin ld = 1; sz = 1; end
      6'b100001: begin ld = 1; sz = 2; sgn = 1; end
      6'b100101: begin ld = 1; sz = 2; end
      6'b100011: begin ld = 1; sz = 4; end
      6'b101000: begin st = 1; sz = 1; end
      6'b101001: begin st = 1; sz = 2; end
      6'b101011: begin st = 1; sz = 4; end
      default: ;
    endcase
    e.err = (ld || st) && ((sz == 2 && k[0]) || (sz == 4 && k != 0));
    e.we  = ld && !e.err;
    e.be  = 4'b0;
    if (st && !e.err) begin
      if (sz == 1) e.be = 4'b1000 >> k;
      else if (sz == 2) e.be = k[1] ? 4'b0011 : 4'b1100;
      else e.be = 4'b1111;
    end
    e.wdata = 0;
    if (st) e.wdata = (sz == 1) ? {4{s[7:0]}} : (sz == 2) ? {2{s[15:0]}} : s;
    e.ldv = 0;
    if (e.we) begin
      by = 8'(r >> (8 * (3 - int'(k))));
      hw = 16'(r >> (k[1] ? 0 : 16));
      if (sz == 1) e.ldv = sgn ? 32'($signed(by)) : {24'b0, by};
      else if (sz == 2) e.ldv = sgn ? 32'($signed(hw)) : {16'b0, hw};
      else e.ldv = r;
    end
    return e;
  endfunction

  task automatic drive(logic [5:0] o, logic [31:0] b, logic [15:0] d,
                       logic [31:0] s, logic [31:0] r, string req);
    @(posedge clk);
    #1;
    op = o; base = b; offs = d; sv = s; rw = r;
    sb.push_back(model(o, b, d, s, r, req));
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (addr !== e.addr || be !== e.be || wdata !== e.wdata ||
          ldv !== e.ldv || we !== e.we || err !== e.err) begin
        n_fail++;
        $display("FAIL %s op=%b addr=%h/%h be=%b/%b wd=%h/%h ld=%h/%h we=%b/%b err=%b/%b (act/exp)",
                 e.req, op, addr, e.addr, be, e.be, wdata, e.wdata,
                 ldv, e.ldv, we, e.we, err, e.err);
      end
    end
  end

  initial begin
    op = 6'b0; base = 0; offs = 0; sv = 0; rw = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset / idle state: opcode 0 is not an access (R2)
    drive(6'b000000, 32'h0, 16'h0, 32'h0, 32'h0, "R2");
    // R1: positive, negative and wrapping displacements
    drive(6'b100011, 32'h0000_1000, 16'h0010, 32'h0, 32'hCAFE_F00D, "R1");
    drive(6'b100011, 32'h0000_1000, 16'hFFF0, 32'h0, 32'h1234_5678, "R1");
    drive(6'b101011, 32'h0000_0004, 16'h8000, 32'hA5A5_5A5A, 32'h0, "R1");
    // R3: byte loads at each offset, both sign states
    for (int k = 0; k < 4; k++) begin
      drive(6'b100000, 32'h200, 16'(k), 32'h0, 32'h80F1_7F02, "R3");
      drive(6'b100100, 32'h200, 16'(k), 32'h0, 32'h80F1_7F02, "R3");
    end
    // R4: halfword loads at offsets 0 and 2, both sign states
    drive(6'b100001, 32'h300, 16'h0, 32'h0, 32'h9234_7ABC, "R4");
    drive(6'b100101, 32'h300, 16'h0, 32'h0, 32'h9234_7ABC, "R4");
    drive(6'b100001, 32'h300, 16'h2, 32'h0, 32'h1234_8ABC, "R4");
    drive(6'b100101, 32'h300, 16'h2, 32'h0, 32'h1234_8ABC, "R4");
    drive(6'b100001, 32'h300, 16'h2, 32'h0, 32'h1234_7ABC, "R4");
    // R5: aligned word load
    drive(6'b100011, 32'h400, 16'h8, 32'h0, 32'hDEAD_BEEF, "R5");
    // R6 / R9: misaligned halfword and word accesses
    drive(6'b100001, 32'h300, 16'h1, 32'h0, 32'hFFFF_FFFF, "R6");
    drive(6'b100101, 32'h300, 16'h3, 32'h0, 32'hFFFF_FFFF, "R9");
    for (int k = 1; k < 4; k++) begin
      drive(6'b100011, 32'h400, 16'(k), 32'h0, 32'hDEAD_BEEF, "R6");
      drive(6'b101011, 32'h400, 16'(k), 32'h1122_3344, 32'h0, "R9");
    end
    drive(6'b101001, 32'h401, 16'h0, 32'h1122_3344, 32'h0, "R9");
    // R7 / R8: stores at each lane
    for (int k = 0; k < 4; k++)
      drive(6'b101000, 32'h500, 16'(k), 32'h1122_33C4, 32'h0, "R7");
    drive(6'b101001, 32'h500, 16'h0, 32'hAABB_CCDD, 32'h0, "R8");
    drive(6'b101001, 32'h500, 16'h2, 32'hAABB_CCDD, 32'h0, "R8");
    drive(6'b101011, 32'h500, 16'h4, 32'h0BAD_F00D, 32'h0, "R8");
    // R2: neighbouring opcodes are inert
    drive(6'b100010, 32'h600, 16'h0, 32'h1, 32'hFFFF_FFFF, "R2");
    drive(6'b101010, 32'h600, 16'h0, 32'h1, 32'hFFFF_FFFF, "R2");
    drive(6'b001000, 32'h600, 16'h1, 32'h1, 32'hFFFF_FFFF, "R2");
    drive(6'b110011, 32'h600, 16'h0, 32'h1, 32'hFFFF_FFFF, "R2");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule